// File: doc/BRIEF.md
# Segment Offset Limit Checker

This block screens every memory operand offset before the access goes to memory, in the way a segmented protection unit does. It takes the raw effective offset from the address calculation. It cuts that offset down to the active address size, either 16 or 32 bits, and the result is the operand's base offset. It then finds the offset of the operand's highest byte using one extra carry bit. That byte is compared with both the segment limit and the top of the offset space. A word or dword that runs past the end of the segment or the offset space therefore faults, instead of wrapping silently back to offset zero.

A limit violation is reported as a stack fault when the request targets the stack segment, and as a general-protection fault otherwise. When alignment checking is on, a misaligned word or dword raises an alignment fault. This check uses the offset itself, before any segment base is added. One request is accepted per cycle. The wrapped base offset and at most one fault flag come back one cycle later, marked by a response valid.

Top module: `seg_limit_chk`

## Requirements
- R1: The response base offset is the request offset truncated to the address size. In 16-bit mode (`req_addr32`=0) it is bits 15:0, zero-extended. In 32-bit mode it is all 32 bits. Any wrap from the address calculation therefore happens before the limit check.
- R2: The access size is encoded on `req_size` as 0=byte, 1=word, 2=dword, and 3 is treated as dword. The bytes of an operand occupy base through base+size-1, computed without wrapping. A limit violation occurs when that last byte is above the effective limit. A byte access checks only its base.
- R3: A violation also occurs when the last byte lies beyond the offset space, whatever the limit. In 16-bit mode that means above 0xFFFF, and in 32-bit mode above 0xFFFFFFFF.
- R4: The effective limit depends on `req_gran`. When `req_gran`=0 it is the 20-bit limit field as given. When `req_gran`=1 it is the field shifted left by 12 with the low 12 bits set to one.
- R5: A limit violation raises `rsp_ss_fault` when `req_stack`=1 and `rsp_gp_fault` when `req_stack`=0.
- R6: With `req_align_en`=1 and no limit violation, `rsp_ac_fault` is raised for a word whose offset bit 0 is set, or for a dword whose offset bits 1:0 are not both zero. A byte never raises it, and neither does any access when `req_align_en`=0.
- R7: A limit violation takes priority over misalignment, so at most one fault flag is high per response.
- R8: `rsp_valid` is high exactly one cycle after a cycle with `req_valid` high. When `rsp_valid` is low, all fault flags are low.
- R9: While reset (`rst_n`=0) is held, `rsp_valid` and all fault flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_offset | input | 32 | Raw effective offset |
| req_addr32 | input | 1 | 1 = 32-bit address size, 0 = 16-bit |
| req_size | input | 2 | Access size: 0 byte, 1 word, 2/3 dword |
| req_limit | input | 20 | Segment limit field |
| req_gran | input | 1 | 1 = limit counted in 4 KiB units |
| req_align_en | input | 1 | Alignment checking enabled |
| req_stack | input | 1 | Request targets the stack segment |
| rsp_valid | output | 1 | Response present |
| rsp_base | output | 32 | Wrapped base offset |
| rsp_gp_fault | output | 1 | General-protection fault |
| rsp_ss_fault | output | 1 | Stack fault |
| rsp_ac_fault | output | 1 | Alignment fault |

## Verification
The following properties are checked by assertions on every cycle:
- the one-cycle response timing;
- the one-hot-or-none fault flags;
- the routing of limit faults by the stack flag;
- the absence of alignment faults for bytes and when checking is off;
- the zero upper half of the base in 16-bit mode.

Only the bench's scenarios can show that faults land on the exact boundaries. These include a word at the top of either offset space, a dword base three bytes below the 32-bit top, the last legal byte under each granularity, and a summed 16-bit offset that wraps to zero without faulting. The bench's behavioural model is compared against these cases and against a stream of random requests.

// File: rtl/seg_chk_pkg.sv
package seg_chk_pkg;

    typedef enum logic [1:0] {
        ACC_BYTE  = 2'd0,
        ACC_WORD  = 2'd1,
        ACC_DWORD = 2'd2,
        ACC_WIDE  = 2'd3
    } acc_size_e;

    typedef struct packed {
        logic        valid;
        logic [31:0] base;
        logic        gp;
        logic        ss;
        logic        ac;
    } chk_rsp_t;

endpackage

// File: rtl/seg_limit_expand.sv
module seg_limit_expand #(
    parameter int LIM_W   = 20,
    parameter int GRAN_SH = 12,
    localparam int EFF_W  = LIM_W + GRAN_SH
) (
    input  logic [LIM_W-1:0] field,
    input  logic             gran,
    output logic [EFF_W-1:0] eff_limit
);
    // Page granularity fills the low bits with ones so the last page is fully usable.
    always_comb begin
        if (gran) eff_limit = {field, {GRAN_SH{1'b1}}};
        else      eff_limit = {{GRAN_SH{1'b0}}, field};
    end
endmodule

// File: rtl/seg_span_check.sv
module seg_span_check
    import seg_chk_pkg::*;
#(
    parameter int OFF_W = 32,
    localparam int HALF_W = OFF_W / 2,
    localparam int EXT_W  = OFF_W + 1
) (
    input  logic [OFF_W-1:0] base,
    input  logic             wide,
    input  acc_size_e        size,
    input  logic [OFF_W-1:0] eff_limit,
    input  logic             align_en,
    output logic             viol,
    output logic             misalign
);
    logic [EXT_W-1:0] span_add;
    logic [EXT_W-1:0] last_byte;
    logic [EXT_W-1:0] space_top;

    always_comb begin
        unique case (size)
            ACC_BYTE: span_add = EXT_W'(0);
            ACC_WORD: span_add = EXT_W'(1);
            default:  span_add = EXT_W'(3);
        endcase
        // Extra carry bit: the last byte can never wrap back to low offsets.
        last_byte = {1'b0, base} + span_add;
        space_top = wide ? {1'b0, {OFF_W{1'b1}}}
                         : {{(EXT_W-HALF_W){1'b0}}, {HALF_W{1'b1}}};
        viol = (last_byte > space_top) || (last_byte > {1'b0, eff_limit});

        unique case (size)
            ACC_BYTE: misalign = 1'b0;
            ACC_WORD: misalign = align_en & base[0];
            default:  misalign = align_en & (|base[1:0]);
        endcase
    end
endmodule

// File: rtl/seg_limit_chk.sv
module seg_limit_chk
    import seg_chk_pkg::*;
#(
    parameter int OFF_W   = 32,
    parameter int LIM_W   = 20,
    parameter int GRAN_SH = 12,
    localparam int HALF_W = OFF_W / 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [OFF_W-1:0] req_offset,
    input  logic             req_addr32,
    input  logic [1:0]       req_size,
    input  logic [LIM_W-1:0] req_limit,
    input  logic             req_gran,
    input  logic             req_align_en,
    input  logic             req_stack,
    output logic             rsp_valid,
    output logic [OFF_W-1:0] rsp_base,
    output logic             rsp_gp_fault,
    output logic             rsp_ss_fault,
    output logic             rsp_ac_fault
);
    logic [OFF_W-1:0] base_w;
    logic [OFF_W-1:0] eff_limit;
    logic             viol;
    logic             misalign;
    chk_rsp_t         rsp_d, rsp_q;

    // Truncate to the address size first; the span check then sees the wrapped base.
    assign base_w = req_addr32 ? req_offset
                               : {{(OFF_W-HALF_W){1'b0}}, req_offset[HALF_W-1:0]};

    seg_limit_expand #(
        .LIM_W   (LIM_W),
        .GRAN_SH (GRAN_SH)
    ) u_limit (
        .field     (req_limit),
        .gran      (req_gran),
        .eff_limit (eff_limit)
    );

    seg_span_check #(
        .OFF_W (OFF_W)
    ) u_span (
        .base      (base_w),
        .wide      (req_addr32),
        .size      (acc_size_e'(req_size)),
        .eff_limit (eff_limit),
        .align_en  (req_align_en),
        .viol      (viol),
        .misalign  (misalign)
    );

    always_comb begin
        rsp_d       = rsp_q;
        rsp_d.valid = req_valid;
        rsp_d.gp    = 1'b0;
        rsp_d.ss    = 1'b0;
        rsp_d.ac    = 1'b0;
        if (req_valid) begin
            rsp_d.base = base_w;
            rsp_d.gp   = viol & ~req_stack;
            rsp_d.ss   = viol & req_stack;
            rsp_d.ac   = misalign & ~viol;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_valid    = rsp_q.valid;
    assign rsp_base     = rsp_q.base;
    assign rsp_gp_fault = rsp_q.gp;
    assign rsp_ss_fault = rsp_q.ss;
    assign rsp_ac_fault = rsp_q.ac;
endmodule

// File: rtl/seg_limit_chk_sva.sv
module seg_limit_chk_sva #(
    parameter int OFF_W = 32,
    parameter int LIM_W = 20,
    localparam int HALF_W = OFF_W / 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic [OFF_W-1:0] req_offset,
    input logic             req_addr32,
    input logic [1:0]       req_size,
    input logic [LIM_W-1:0] req_limit,
    input logic             req_gran,
    input logic             req_align_en,
    input logic             req_stack,
    input logic             rsp_valid,
    input logic [OFF_W-1:0] rsp_base,
    input logic             rsp_gp_fault,
    input logic             rsp_ss_fault,
    input logic             rsp_ac_fault
);
    assert_rsp_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    assert_no_spurious_rsp_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> !(rsp_gp_fault || rsp_ss_fault || rsp_ac_fault));
    assert_one_fault_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({rsp_gp_fault, rsp_ss_fault, rsp_ac_fault}) <= 1);
    assert_ss_needs_stack_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_stack) |=> !rsp_ss_fault);
    assert_gp_not_stack_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_stack) |=> !rsp_gp_fault);
    assert_byte_aligned_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_size == 2'd0) |=> !rsp_ac_fault);
    assert_align_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_align_en) |=> !rsp_ac_fault);
    assert_narrow_base_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_addr32) |=> (rsp_base[OFF_W-1:HALF_W] == '0));
    assert_narrow_byte_ok_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_size == 2'd0 && req_gran && (&req_limit)) |=>
        !(rsp_gp_fault || rsp_ss_fault));
endmodule

bind seg_limit_chk seg_limit_chk_sva #(
    .OFF_W (OFF_W),
    .LIM_W (LIM_W)
) u_sva (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_offset   (req_offset),
    .req_addr32   (req_addr32),
    .req_size     (req_size),
    .req_limit    (req_limit),
    .req_gran     (req_gran),
    .req_align_en (req_align_en),
    .req_stack    (req_stack),
    .rsp_valid    (rsp_valid),
    .rsp_base     (rsp_base),
    .rsp_gp_fault (rsp_gp_fault),
    .rsp_ss_fault (rsp_ss_fault),
    .rsp_ac_fault (rsp_ac_fault)
);

// File: tb/sim_seg_limit_chk.sv
module sim_seg_limit_chk;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_offset = '0;
    logic        req_addr32 = 1'b0;
    logic [1:0]  req_size = '0;
    logic [19:0] req_limit = '0;
    logic        req_gran = 1'b0;
    logic        req_align_en = 1'b0;
    logic        req_stack = 1'b0;
    logic        rsp_valid;
    logic [31:0] rsp_base;
    logic        rsp_gp_fault, rsp_ss_fault, rsp_ac_fault;

    int checks = 0;
    int errors = 0;

    typedef struct {
        bit          v;
        logic [31:0] base;
        bit          gp;
        bit          ss;
        bit          ac;
        string       tag;
    } exp_t;

    exp_t pend[$];

    always #10 clk = ~clk;

    seg_limit_chk u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_offset(req_offset),
        .req_addr32(req_addr32), .req_size(req_size), .req_limit(req_limit),
        .req_gran(req_gran), .req_align_en(req_align_en), .req_stack(req_stack),
        .rsp_valid(rsp_valid), .rsp_base(rsp_base), .rsp_gp_fault(rsp_gp_fault),
        .rsp_ss_fault(rsp_ss_fault), .rsp_ac_fault(rsp_ac_fault)
    );

    task automatic check(string tag, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Behavioural reference from the requirements.
    function automatic exp_t model(bit v, longint off, bit a32, int sz, longint lim,
                                   bit gran, bit ae, bit stk, string tag);
        exp_t e;
        longint base, last, top, efl;
        int n;
        e.v = v; e.tag = tag; e.gp = 0; e.ss = 0; e.ac = 0; e.base = 'x;
        if (!v) return e;
        base = a32 ? (off & 64'hFFFF_FFFF) : (off & 64'hFFFF);
        n = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
        last = base + n - 1;
        top = a32 ? 64'hFFFF_FFFF : 64'hFFFF;
        efl = gran ? ((lim << 12) | 64'hFFF) : lim;
        e.base = base[31:0];
        if (last > top || last > efl) begin
            if (stk) e.ss = 1; else e.gp = 1;
        end else if (ae && ((n == 2 && base[0]) || (n == 4 && base[1:0] != 0))) begin
            e.ac = 1;
        end
        return e;
    endfunction

    task automatic compare_pending();
        exp_t e;
        if (pend.size() == 0) return;
        e = pend.pop_front();
        check({"R8 valid ", e.tag}, rsp_valid, e.v);
        if (e.v) begin
            check({"R1 base ", e.tag}, rsp_base, e.base);
            check({"gp ", e.tag}, rsp_gp_fault, e.gp);
            check({"ss ", e.tag}, rsp_ss_fault, e.ss);
            check({"ac ", e.tag}, rsp_ac_fault, e.ac);
        end else begin
            check({"R8 quiet flags ", e.tag}, {rsp_gp_fault, rsp_ss_fault, rsp_ac_fault}, 0);
        end
    endtask

    task automatic step(bit v, logic [31:0] off, bit a32, int sz, logic [19:0] lim,
                        bit gran, bit ae, bit stk, string tag);
        @(negedge clk);
        compare_pending();
        req_valid = v; req_offset = off; req_addr32 = a32; req_size = 2'(sz);
        req_limit = lim; req_gran = gran; req_align_en = ae; req_stack = stk;
        pend.push_back(model(v, off, a32, sz, lim, gran, ae, stk, tag));
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog: actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R9 reset valid", rsp_valid, 0);
        check("R9 reset flags", {rsp_gp_fault, rsp_ss_fault, rsp_ac_fault}, 0);
        rst_n = 1'b1;

        step(1, 32'h0000_FFFF, 0, 1, 20'h0FFFF, 0, 0, 0, "R3 word at 16-bit top");
        step(1, 32'h0000_FFFF, 0, 1, 20'hFFFFF, 1, 0, 0, "R3 16-bit top big limit");
        step(1, 32'h0001_0000, 0, 1, 20'h0FFFF, 0, 0, 0, "R1 summed wrap to zero");
        step(1, 32'h1234_5678, 0, 0, 20'h0FFFF, 0, 0, 0, "R1 16-bit truncate");
        step(1, 32'hFFFF_FFFF, 1, 1, 20'hFFFFF, 1, 0, 0, "R3 word at 32-bit top");
        step(1, 32'hFFFF_FFFD, 1, 2, 20'hFFFFF, 1, 0, 0, "R3 dword FFFFFFFD");
        step(1, 32'hFFFF_FFFC, 1, 2, 20'hFFFFF, 1, 0, 0, "R2 dword FFFFFFFC ok");
        step(1, 32'hFFFF_FFFF, 1, 0, 20'hFFFFF, 1, 0, 0, "R2 byte at top ok");
        step(1, 32'hFFFF_FFFE, 1, 3, 20'hFFFFF, 1, 0, 0, "R2 size 3 as dword");
        step(1, 32'h0000_0FFD, 1, 2, 20'h01000, 0, 0, 0, "R4 byte gran last ok");
        step(1, 32'h0000_0FFE, 1, 2, 20'h01000, 0, 0, 0, "R4 byte gran over");
        step(1, 32'h0000_1FFC, 1, 2, 20'h00001, 1, 0, 0, "R4 page gran last ok");
        step(1, 32'h0000_1FFD, 1, 2, 20'h00001, 1, 0, 0, "R4 page gran over");
        step(1, 32'h0000_FFFF, 0, 1, 20'h0FFFF, 0, 0, 1, "R5 push with sp 1");
        step(1, 32'h0000_2000, 1, 0, 20'h00FFF, 0, 0, 1, "R5 stack byte over");
        step(1, 32'h0000_0003, 1, 1, 20'h0FFFF, 0, 1, 0, "R6 word odd");
        step(1, 32'h0000_0002, 1, 2, 20'h0FFFF, 0, 1, 0, "R6 dword at 2");
        step(1, 32'h0000_0004, 1, 2, 20'h0FFFF, 0, 1, 0, "R6 dword aligned");
        step(1, 32'h0000_0003, 1, 0, 20'h0FFFF, 0, 1, 0, "R6 byte never");
        step(1, 32'h0000_0003, 1, 1, 20'h0FFFF, 0, 0, 0, "R6 check off");
        step(1, 32'h0000_0FFF, 1, 1, 20'h00FFF, 0, 1, 0, "R7 limit over align");
        step(1, 32'h0000_0FFF, 1, 1, 20'h00FFF, 0, 1, 1, "R7 stack over align");
        step(0, 32'h0000_0000, 1, 1, 20'h00000, 0, 1, 0, "R8 idle");
        step(0, 32'hFFFF_FFFF, 1, 2, 20'h00000, 0, 1, 1, "R8 idle again");

        for (int i = 0; i < 400; i++) begin
            logic [31:0] o;
            logic [19:0] l;
            o = $urandom();
            if (i % 3 == 0) o = o | 32'hFFFF_FFF0;
            if (i % 5 == 0) o = o | 32'h0000_FFF8;
            l = 20'($urandom());
            if (i % 4 == 0) l = 20'hFFFFF;
            step(($urandom() % 8) != 0, o, 1'($urandom()), int'($urandom() % 4), l,
                 1'($urandom()), 1'($urandom()), 1'($urandom()), "R2 random mix");
        end

        @(negedge clk);
        compare_pending();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule